// File: doc/BRIEF.md
# Four-Phase Handshake Debug Register Target

This block is a small register bank reached over a debug access port. A master, possibly in another clock domain, raises a request level together with an address, a write flag and write data. The target answers by raising an acknowledge level and, for reads, by presenting read data. Both outputs are held frozen until the master drops the request. Only then does acknowledge fall, which completes a full four-phase handshake.

The bank holds `NUM_RW` writable 32-bit registers, a read-only identification word and a read-only counter of write requests. The target captures a transaction exactly once, on the cycle in which it first sees the request high. A request that is held high for any length of time never repeats a write, never times out and never changes the response.

Top module: `hsrt_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ackOut` is 0 and `rdataOut` is 0. Writable register i holds `RST_BASE + i` (default 32'hC0DE_0000 + i) and the write counter holds 0.
- R2: `ackOut` rises on the first clock edge at which `reqIn` is sampled high while idle. It falls on the first clock edge at which `reqIn` is sampled low.
- R3: While `reqIn` stays high, `ackOut` stays high for any number of cycles, with no timeout.
- R4: While `ackOut` is high, `rdataOut` does not change. A read (`wrIn`=0) returns the value of the addressed register at the capture edge.
- R5: A write (`wrIn`=1) to a writable address 0..NUM_RW-1 updates that register exactly once, however long the request is held.
- R6: A read of address `ID_ADDR` (default 8'hF0) returns `ID_VALUE` (default 32'h5EED_0001). A write to that address is acknowledged and has no effect.
- R7: A read of any unmapped address returns 0 and is acknowledged. A write to an unmapped address is acknowledged and changes no register.
- R8: A read of address `CNT_ADDR` (default 8'hF1) returns the number of write requests accepted since reset. This count includes writes to read-only and unmapped addresses, and each request counts once. A write to `CNT_ADDR` does not load the counter.
- R9: The address, write flag and write data are taken only on the capture edge. Changes to them while acknowledge is high have no effect.
- R10: A write transaction leaves `rdataOut` at its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 1 | Request level from the master |
| wrIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | AW | Register address |
| wdataIn | input | DW | Write data |
| rdataOut | output | DW | Read data, held while acknowledged |
| ackOut | output | 1 | Acknowledge level |

## Verification
The hardest case to reach from the ports is a request held high far longer than one cycle while the master-side inputs change underneath it. In that window a faulty design would write a second time, recapture the address or let the read data drift. The stimulus holds every transaction for a varying number of cycles and scrambles the address, write flag and data on each held cycle. It includes one very long hold on a write. It then reads the write counter and the registers back to show that exactly one capture took place.

// File: rtl/hsrt_pkg.sv
package hsrt_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } hsState_t;

  // Strobes from control to datapath, valid for one cycle at capture.
  typedef struct packed {
    logic capture;
    logic isWrite;
  } hsStrobe_t;

endpackage

// File: rtl/hsrt_ctrl.sv
module hsrt_ctrl
  import hsrt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqIn,
  input  logic      wrIn,
  output hsStrobe_t strobe,
  output logic      ackOut
);

  hsState_t state;
  hsState_t nextState;

  always_comb begin
    nextState      = state;
    strobe.capture = 1'b0;
    strobe.isWrite = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqIn) begin
          strobe.capture = 1'b1;
          strobe.isWrite = wrIn;
          nextState      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        // Stay here for as long as the master keeps the request up.
        if (!reqIn) begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  assign ackOut = (state == ST_HOLD);

endmodule

// File: rtl/hsrt_decode.sv
module hsrt_decode #(
  parameter int          AW       = 8,
  parameter int          NUM_RW   = 4,
  parameter logic [AW-1:0] ID_ADDR  = 8'hF0,
  parameter logic [AW-1:0] CNT_ADDR = 8'hF1
) (
  input  logic [AW-1:0]     addr,
  output logic [NUM_RW-1:0] rwHit,
  output logic              idHit,
  output logic              cntHit
);

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rwHit
    localparam logic [AW-1:0] SLOT_ADDR = AW'(i);
    assign rwHit[i] = (addr == SLOT_ADDR);
  end

  assign idHit  = (addr == ID_ADDR);
  assign cntHit = (addr == CNT_ADDR);

endmodule

// File: rtl/hsrt_datapath.sv
module hsrt_datapath
  import hsrt_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            NUM_RW   = 4,
  parameter logic [DW-1:0] ID_VALUE = 32'h5EED_0001,
  parameter logic [DW-1:0] RST_BASE = 32'hC0DE_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  hsStrobe_t         strobe,
  input  logic [NUM_RW-1:0] rwHit,
  input  logic              idHit,
  input  logic              cntHit,
  input  logic [DW-1:0]     wdataIn,
  output logic [DW-1:0]     rdataOut
);

  logic [DW-1:0] rwRegs [NUM_RW];
  logic [DW-1:0] wrCount;
  logic [DW-1:0] rdMux;
  logic [DW-1:0] rdData;

  logic doWrite;
  logic doRead;

  assign doWrite = strobe.capture & strobe.isWrite;
  assign doRead  = strobe.capture & ~strobe.isWrite;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rwReg
    localparam logic [DW-1:0] RST_VAL = RST_BASE + DW'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        rwRegs[i] <= RST_VAL;
      end else if (doWrite && rwHit[i]) begin
        rwRegs[i] <= wdataIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrCount <= '0;
    end else if (doWrite) begin
      wrCount <= wrCount + DW'(1);
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (rwHit[i]) rdMux = rwRegs[i];
    end
    if (idHit)  rdMux = ID_VALUE;
    if (cntHit) rdMux = wrCount;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (doRead) begin
      rdData <= rdMux;
    end
  end

  assign rdataOut = rdData;

endmodule

// File: rtl/hsrt_top.sv
module hsrt_top
  import hsrt_pkg::*;
#(
  parameter int              AW       = 8,
  parameter int              DW       = 32,
  parameter int              NUM_RW   = 4,
  parameter logic [AW-1:0]   ID_ADDR  = 8'hF0,
  parameter logic [AW-1:0]   CNT_ADDR = 8'hF1,
  parameter logic [DW-1:0]   ID_VALUE = 32'h5EED_0001,
  parameter logic [DW-1:0]   RST_BASE = 32'hC0DE_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqIn,
  input  logic          wrIn,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] wdataIn,
  output logic [DW-1:0] rdataOut,
  output logic          ackOut
);

  hsStrobe_t         strobe;
  logic [NUM_RW-1:0] rwHit;
  logic              idHit;
  logic              cntHit;

  hsrt_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .reqIn  (reqIn),
    .wrIn   (wrIn),
    .strobe (strobe),
    .ackOut (ackOut)
  );

  hsrt_decode #(
    .AW       (AW),
    .NUM_RW   (NUM_RW),
    .ID_ADDR  (ID_ADDR),
    .CNT_ADDR (CNT_ADDR)
  ) u_decode (
    .addr   (addrIn),
    .rwHit  (rwHit),
    .idHit  (idHit),
    .cntHit (cntHit)
  );

  hsrt_datapath #(
    .DW       (DW),
    .NUM_RW   (NUM_RW),
    .ID_VALUE (ID_VALUE),
    .RST_BASE (RST_BASE)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rwHit    (rwHit),
    .idHit    (idHit),
    .cntHit   (cntHit),
    .wdataIn  (wdataIn),
    .rdataOut (rdataOut)
  );

endmodule

// File: rtl/hsrt_chk.sv
module hsrt_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reqIn,
  input logic          ackOut,
  input logic [DW-1:0] rdataOut
);

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (ackOut && !$past(ackOut)) |-> $past(reqIn)); // R2

  AST_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
    (!ackOut && reqIn) |=> ackOut); // R2

  AST_ACK_FALL: assert property (@(posedge clk) disable iff (rst)
    (ackOut && !reqIn) |=> !ackOut); // R2

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ackOut && reqIn) |=> ackOut); // R3

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    ackOut |=> (!ackOut || $stable(rdataOut))); // R4

endmodule

bind hsrt_top hsrt_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqIn    (reqIn),
  .ackOut   (ackOut),
  .rdataOut (rdataOut)
);

// File: tb/test_hsrt_top.sv
module test_hsrt_top;

  localparam int          AW       = 8;
  localparam int          DW       = 32;
  localparam int          NUM_RW   = 4;
  localparam logic [7:0]  ID_ADDR  = 8'hF0;
  localparam logic [7:0]  CNT_ADDR = 8'hF1;
  localparam logic [31:0] ID_VALUE = 32'h5EED_0001;
  localparam logic [31:0] RST_BASE = 32'hC0DE_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqIn = 1'b0;
  logic          wrIn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] wdataIn = '0;
  logic [DW-1:0] rdataOut;
  logic          ackOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] model [NUM_RW];
  logic [31:0] wrModel;

  always #10 clk = ~clk; // 50 MHz

  hsrt_top i_hsrt_top (
    .clk      (clk),
    .rst      (rst),
    .reqIn    (reqIn),
    .wrIn     (wrIn),
    .addrIn   (addrIn),
    .wdataIn  (wdataIn),
    .rdataOut (rdataOut),
    .ackOut   (ackOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a < NUM_RW)    return model[a];
    if (a == ID_ADDR)  return ID_VALUE;
    if (a == CNT_ADDR) return wrModel;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pattern(input int a, input int pass);
    return (32'h9E37_79B9 * 32'(a + 1)) ^ (32'h0101_0101 * 32'(pass));
  endfunction

  // One full handshake; inputs scrambled on every held cycle (R9).
  task automatic txn(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input int hold, output logic [31:0] rd);
    logic [31:0] prevRd;
    prevRd  = rdataOut;
    reqIn   = 1'b1;
    wrIn    = wr;
    addrIn  = a;
    wdataIn = d;
    @(negedge clk);
    chk(ackOut === 1'b1, "R2 ack rise", 32'(ackOut), 32'h1);
    rd = rdataOut;
    if (wr) chk(rd === prevRd, "R10 rdata kept on write", rd, prevRd);
    for (int k = 0; k < hold; k++) begin
      addrIn  = ~a ^ 8'(k);
      wdataIn = ~d ^ 32'(k);
      wrIn    = ~wr;
      @(negedge clk);
      chk(ackOut === 1'b1, "R3 ack held", 32'(ackOut), 32'h1);
      chk(rdataOut === rd, "R4 rdata stable", rdataOut, rd);
    end
    reqIn = 1'b0;
    @(negedge clk);
    chk(ackOut === 1'b0, "R2 ack fall", 32'(ackOut), 32'h0);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < NUM_RW; i++) model[i] = RST_BASE + 32'(i);
    wrModel = 32'h0;
    repeat (3) @(negedge clk);
    chk(ackOut === 1'b0, "R1 ack in reset", 32'(ackOut), 32'h0);
    chk(rdataOut === 32'h0, "R1 rdata in reset", rdataOut, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(ackOut === 1'b0, "R1 ack after reset", 32'(ackOut), 32'h0);

    // Read sweep from reset values: R1, R6, R7, R8.
    for (int a = 0; a < 256; a++) begin
      txn(1'b0, 8'(a), 32'hDEAD_0000 | 32'(a), a % 4, rd);
      chk(rd === expRead(8'(a)), "R1 R6 R7 R8 reset read", rd, expRead(8'(a)));
    end

    // Write sweep over every address, then read sweep: R5, R6, R7, R8, R9.
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 256; a++) begin
        txn(1'b1, 8'(a), pattern(a, pass), (a + pass) % 5, rd);
        if (a < NUM_RW) model[a] = pattern(a, pass);
        wrModel = wrModel + 32'h1;
      end
      for (int a = 0; a < 256; a++) begin
        txn(1'b0, 8'(a), 32'h0, (a + 1) % 3, rd);
        chk(rd === expRead(8'(a)), "R5 R6 R7 R8 R9 readback", rd, expRead(8'(a)));
      end
    end

    // Very long hold on a write: exactly one update and one count (R5, R8).
    txn(1'b1, 8'h1, 32'h1234_5678, 300, rd);
    model[1] = 32'h1234_5678;
    wrModel = wrModel + 32'h1;
    txn(1'b0, CNT_ADDR, 32'h0, 0, rd);
    chk(rd === wrModel, "R8 single count on long hold", rd, wrModel);
    txn(1'b0, 8'h1, 32'h0, 0, rd);
    chk(rd === model[1], "R5 long-hold write", rd, model[1]);

    // Long hold on a read of the ID word (R3, R4, R6).
    txn(1'b0, ID_ADDR, 32'h0, 400, rd);
    chk(rd === ID_VALUE, "R6 id read", rd, ID_VALUE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule